// File: doc/BRIEF.md
# Byte Transfer Unit with One-Shot Strong Pullup

This block moves whole bytes over a single-wire bus by driving a bit-slot engine below it, one slot at a time. The host starts one of three operations with a single-cycle command: write a byte, read a byte, or touch a byte. A touch sends each data bit and keeps the level the bus returns in the same slot. Every operation ends with a one-cycle `done` pulse, and the byte that was gathered appears on `result`.

The block can also hold a one-shot strong-pullup request. The host loads a duration in milliseconds, and zero means that no pullup is wanted. The next write raises the pullup enable at the moment it issues its final slot, and keeps it high for the loaded time after that slot completes. The enable then drops, the stored request clears itself, and `done` is raised. A millisecond prescaler built from the clock times the hold. If the pullup hardware is switched off, the write still waits the same time but leaves the enable low.

Top module: `btu_byte_xfer`

## Requirements
- R1: After synchronous reset, `done`, `bit_req`, `spu_en` and `result` are all 0, and no pullup request is pending.
- R2: A write (cmd_op = 2'b01) issues exactly eight slots, least significant bit first. Slot i carries `cmd_data[i]`, and `result` is 8'h00 when the write completes.
- R3: A read (cmd_op = 2'b10) issues eight slots, all with value 1. The sample returned by slot i lands in `result[i]`.
- R4: A touch (cmd_op = 2'b11) issues slot i with `cmd_data[i]` and stores the sample returned by that slot in `result[i]`.
- R5: The block ignores a command with cmd_op = 2'b00, and ignores any command or `pu_load` that arrives while a transfer is in progress. It issues no slots for them, and no pullup request is stored.
- R6: When a write starts with a nonzero pullup request pending and `pu_hw_en` = 1, `spu_en` stays low through slots 0 to 6. It rises in the same cycle that `bit_req` is raised for slot 7.
- R7: A write with a pending duration of N ms raises `done` exactly N·CLK_PER_MS clock edges after the edge that consumes slot 7's `bit_done`. `spu_en` falls on that same edge.
- R8: The pullup request is one-shot. The write after a held write raises `done` on the edge that consumes slot 7's `bit_done` and leaves `spu_en` low.
- R9: Loading a duration of zero cancels an earlier request, so the next write has no hold and no pullup.
- R10: With `pu_hw_en` = 0, a write with a pending request still waits its full duration, but `spu_en` never rises.
- R11: Reads and touches never raise `spu_en`, add no hold and leave the pending request in place for the next write.
- R12: `done` is high for exactly one cycle. `result` keeps its value until the next operation completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken only while idle |
| cmd_op | input | 2 | 00 none, 01 write, 10 read, 11 touch |
| cmd_data | input | 8 | Byte to send for write and touch |
| pu_load | input | 1 | Load `pu_ms` as the pending pullup request (only while idle) |
| pu_ms | input | 16 | Pullup duration in milliseconds; zero cancels |
| pu_hw_en | input | 1 | Strong-pullup hardware present and enabled |
| result | output | 8 | Byte assembled from the slot samples |
| done | output | 1 | One-cycle completion pulse |
| bit_req | output | 1 | One-cycle request for a bit slot |
| bit_val | output | 1 | Value of the requested slot |
| bit_done | input | 1 | Slot engine reports the slot finished |
| bit_sample | input | 1 | Bus level sampled in the finished slot |
| spu_en | output | 1 | Strong-pullup enable |

## Verification
The first `bit_req` goes high on the edge that accepts the command. Each later request goes high on the edge that consumes the previous `bit_done`. `done` goes high on the edge that consumes slot 7's `bit_done`, or N·CLK_PER_MS edges after that edge when a hold is pending. The bench counts clock edges and stamps the edge that will consume each `bit_done` it drives. For every transfer it compares the edge at which `done` is seen with that stamp plus the expected hold. It counts the cycles in which `spu_en` is high and compares that count with the distance from the slot-7 request to `done`. All of these are sampled on the falling edge, after the registered outputs have settled.

// File: rtl/btu_pkg.sv
package btu_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_TOUCH = 2'b11
  } btu_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SLOT = 2'd1,
    ST_HOLD = 2'd2
  } btu_state_e;
endpackage

// File: rtl/btu_ms_prescale.sv
module btu_ms_prescale #(
  parameter int CLK_PER_MS = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  generate
    if (CLK_PER_MS <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_count
      localparam int PW = $clog2(CLK_PER_MS);
      localparam logic [PW-1:0] TOP = PW'(CLK_PER_MS - 1);
      logic [PW-1:0] pre;

      assign tick = run && (pre == TOP);

      always_ff @(posedge clk) begin
        if (rst || !run) pre <= '0;
        else if (tick)   pre <= '0;
        else             pre <= pre + 1'b1;
      end

      AST_PRE_RANGE: assert property (@(posedge clk) disable iff (rst)
        pre <= TOP); // R7
    end
  endgenerate
endmodule

// File: rtl/btu_hold_timer.sv
module btu_hold_timer #(
  parameter int MS_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            tick,
  input  logic [MS_W-1:0] target,
  output logic            expired
);
  logic [MS_W-1:0] elapsed;

  assign expired = tick && (({1'b0, elapsed} + (MS_W+1)'(1)) == {1'b0, target});

  always_ff @(posedge clk) begin
    if (rst || !run) elapsed <= '0;
    else if (tick)   elapsed <= elapsed + 1'b1;
  end

  AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (rst)
    (run && target != '0) |-> (elapsed < target)); // R7
endmodule

// File: rtl/btu_shreg.sv
module btu_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= {sin, q[W-1:1]};
  end
endmodule

// File: rtl/btu_byte_xfer.sv
module btu_byte_xfer
  import btu_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int MS_W       = 16,
  parameter int CLK_PER_MS = 50000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              pu_load,
  input  logic [MS_W-1:0]   pu_ms,
  input  logic              pu_hw_en,
  output logic [DATA_W-1:0] result,
  output logic              done,
  output logic              bit_req,
  output logic              bit_val,
  input  logic              bit_done,
  input  logic              bit_sample,
  output logic              spu_en
);
  localparam int CW = $clog2(DATA_W);
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  btu_state_e        st;
  btu_op_e           op_q;
  btu_op_e           op_in;
  logic [CW-1:0]     idx;
  logic [MS_W-1:0]   pend;
  logic [DATA_W-1:0] sr;
  logic [DATA_W-1:0] load_val;
  logic              accept;
  logic              slot_end;
  logic              need_hold;
  logic              in_hold;
  logic              ms_tick;
  logic              hold_exp;

  assign op_in     = btu_op_e'(cmd_op);
  assign accept    = (st == ST_IDLE) && cmd_valid && (op_in != OP_NONE);
  assign load_val  = (op_in == OP_READ) ? {DATA_W{1'b1}} : cmd_data;
  assign slot_end  = (st == ST_SLOT) && bit_done;
  assign need_hold = (op_q == OP_WRITE) && (pend != '0);
  assign in_hold   = (st == ST_HOLD);

  btu_shreg #(.W(DATA_W)) u_sr (
    .clk(clk), .rst(rst), .load(accept), .load_val(load_val),
    .shift(slot_end), .sin(bit_sample), .q(sr)
  );

  btu_ms_prescale #(.CLK_PER_MS(CLK_PER_MS)) u_pre (
    .clk(clk), .rst(rst), .run(in_hold), .tick(ms_tick)
  );

  btu_hold_timer #(.MS_W(MS_W)) u_hold (
    .clk(clk), .rst(rst), .run(in_hold), .tick(ms_tick),
    .target(pend), .expired(hold_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      op_q    <= OP_NONE;
      idx     <= '0;
      bit_req <= 1'b0;
      bit_val <= 1'b0;
      spu_en  <= 1'b0;
      done    <= 1'b0;
      result  <= '0;
      pend    <= '0;
    end else begin
      bit_req <= 1'b0;
      done    <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (pu_load) pend <= pu_ms;
          if (accept) begin
            op_q    <= op_in;
            idx     <= '0;
            bit_req <= 1'b1;
            bit_val <= load_val[0];
            st      <= ST_SLOT;
          end
        end
        ST_SLOT: begin
          if (bit_done) begin
            if (idx == LAST) begin
              result <= (op_q == OP_WRITE) ? '0 : {bit_sample, sr[DATA_W-1:1]};
              if (need_hold) begin
                st <= ST_HOLD;
              end else begin
                done <= 1'b1;
                st   <= ST_IDLE;
              end
            end else begin
              idx     <= idx + 1'b1;
              bit_req <= 1'b1;
              bit_val <= sr[1];
              if (((idx + 1'b1) == LAST) && need_hold && pu_hw_en) spu_en <= 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (hold_exp) begin
            spu_en <= 1'b0;
            pend   <= '0;
            done   <= 1'b1;
            st     <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    bit_req |=> !bit_req); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !bit_req); // R5
  AST_SPU_LAST_SLOT: assert property (@(posedge clk) disable iff (rst)
    $rose(spu_en) |-> (bit_req && idx == LAST)); // R6
  AST_SPU_FALL_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(spu_en) |-> done); // R7
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    (done && op_q == OP_WRITE) |-> (pend == '0)); // R8
  AST_SPU_HW_OFF: assert property (@(posedge clk) disable iff (rst)
    $rose(spu_en) |-> pu_hw_en); // R10
  AST_SPU_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
    spu_en |-> (op_q == OP_WRITE)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R12
endmodule

// File: tb/sim_btu_byte_xfer.sv
module sim_btu_byte_xfer;
  localparam int P   = 20;
  localparam int LAT = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [7:0] cmd_data = 8'h00;
  logic       pu_load = 1'b0;
  logic [15:0] pu_ms = 16'd0;
  logic       pu_hw_en = 1'b1;
  logic [7:0] result;
  logic       done, bit_req, bit_val, spu_en;
  logic       bit_done = 1'b0;
  logic       bit_sample = 1'b0;

  btu_byte_xfer #(.DATA_W(8), .MS_W(16), .CLK_PER_MS(P)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .pu_load(pu_load), .pu_ms(pu_ms),
    .pu_hw_en(pu_hw_en), .result(result), .done(done),
    .bit_req(bit_req), .bit_val(bit_val), .bit_done(bit_done),
    .bit_sample(bit_sample), .spu_en(spu_en)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  // slot engine model and monitor
  logic [7:0] resp = 8'h00;
  logic [7:0] vals, spu_at, cap_vals, cap_spu, cap_res;
  int idx = 0, cd = 0, cur = 0, cur_val = 0;
  int t_bd = 0, t_req7 = 0, cap_t_done = 0, cap_n = 0;
  int done_cnt = 0, spu_cnt = 0, tot_req = 0, dbl_done = 0;
  bit prev_done = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      cd = 0; idx = 0; prev_done = 1'b0; bit_done <= 1'b0;
    end else begin
      if (done) begin
        if (prev_done) dbl_done++;
        cap_vals = vals; cap_spu = spu_at; cap_n = idx; cap_res = result;
        cap_t_done = cyc; idx = 0; done_cnt++;
      end
      prev_done = done;
      if (spu_en) spu_cnt++;
      bit_done <= 1'b0;
      if (cd != 0) begin
        cd--;
        if (cd == 0) begin
          bit_done   <= 1'b1;
          bit_sample <= cur_val[0] & resp[cur];
          t_bd = cyc + 1;
        end
      end
      if (bit_req) begin
        tot_req++;
        cur = (idx < 8) ? idx : 7;
        cur_val = int'(bit_val);
        vals[cur] = bit_val;
        spu_at[cur] = spu_en;
        if (cur == 7) t_req7 = cyc;
        idx++;
        cd = LAT;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int s_spu0 = 0;

  task automatic run_op(input logic [1:0] op, input logic [7:0] data, input bit inject);
    int d0;
    bit got;
    d0 = done_cnt;
    s_spu0 = spu_cnt;
    got = 1'b0;
    @(negedge clk);
    cmd_valid <= 1'b1; cmd_op <= op; cmd_data <= data;
    @(negedge clk);
    cmd_valid <= 1'b0; cmd_op <= 2'b00;
    if (inject) begin
      repeat (3) @(negedge clk);
      cmd_valid <= 1'b1; cmd_op <= 2'b10; cmd_data <= ~data;
      pu_load <= 1'b1; pu_ms <= 16'd3;
      @(negedge clk);
      cmd_valid <= 1'b0; cmd_op <= 2'b00; pu_load <= 1'b0; pu_ms <= 16'd0;
    end
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk); #1;
      if (done_cnt != d0) begin got = 1'b1; break; end
    end
    chk(got, "R12 done timeout", int'(got), 1);
  endtask

  task automatic set_pu(input int ms);
    @(negedge clk);
    pu_load <= 1'b1; pu_ms <= 16'(ms);
    @(negedge clk);
    pu_load <= 1'b0; pu_ms <= 16'd0;
  endtask

  task automatic t_write(input logic [7:0] data, input int hold_ms, input bit exp_spu, input string tag);
    run_op(2'b01, data, 1'b0);
    chk(cap_n == 8, {tag, " R2 slot count"}, cap_n, 8);
    chk(cap_vals == data, {tag, " R2 slot values"}, int'(cap_vals), int'(data));
    chk(cap_res == 8'h00, {tag, " R2 write result"}, int'(cap_res), 0);
    chk(cap_t_done - t_bd == hold_ms * P, {tag, " hold latency"}, cap_t_done - t_bd, hold_ms * P);
    if (exp_spu) begin
      chk(cap_spu == 8'h80, {tag, " R6 pullup only at slot 7"}, int'(cap_spu), 8'h80);
      chk(spu_cnt - s_spu0 == cap_t_done - t_req7, {tag, " R7 pullup width"},
          spu_cnt - s_spu0, cap_t_done - t_req7);
    end else begin
      chk(spu_cnt - s_spu0 == 0, {tag, " pullup stays low"}, spu_cnt - s_spu0, 0);
    end
    chk(spu_en == 1'b0, {tag, " R7 pullup off after done"}, int'(spu_en), 0);
  endtask

  task automatic t_read(input logic [7:0] r, input string tag);
    resp = r;
    run_op(2'b10, 8'h00, 1'b0);
    chk(cap_vals == 8'hFF, {tag, " R3 read slots all ones"}, int'(cap_vals), 8'hFF);
    chk(cap_res == r, {tag, " R3 read result"}, int'(cap_res), int'(r));
    chk(cap_t_done == t_bd, {tag, " R11 no hold on read"}, cap_t_done - t_bd, 0);
    chk(spu_cnt == s_spu0, {tag, " R11 no pullup on read"}, spu_cnt - s_spu0, 0);
  endtask

  task automatic t_touch(input logic [7:0] d, input logic [7:0] r, input bit inject, input string tag);
    resp = r;
    run_op(2'b11, d, inject);
    chk(cap_n == 8, {tag, " R5 eight slots only"}, cap_n, 8);
    chk(cap_vals == d, {tag, " R4 touch slot values"}, int'(cap_vals), int'(d));
    chk(cap_res == (d & r), {tag, " R4 touch result"}, int'(cap_res), int'(d & r));
    chk(spu_cnt == s_spu0, {tag, " R11 no pullup on touch"}, spu_cnt - s_spu0, 0);
  endtask

  task automatic t_reset_state();
    chk(done == 1'b0 && bit_req == 1'b0, "R1 done/bit_req", int'({done, bit_req}), 0);
    chk(spu_en == 1'b0, "R1 spu_en", int'(spu_en), 0);
    chk(result == 8'h00, "R1 result", int'(result), 0);
  endtask

  task automatic t_noop();
    int r0, d0;
    r0 = tot_req; d0 = done_cnt;
    @(negedge clk);
    cmd_valid <= 1'b1; cmd_op <= 2'b00; cmd_data <= 8'h55;
    @(negedge clk);
    cmd_valid <= 1'b0;
    repeat (20) @(negedge clk);
    #1;
    chk(tot_req == r0, "R5 opcode 0 issues no slot", tot_req - r0, 0);
    chk(done_cnt == d0, "R5 opcode 0 gives no done", done_cnt - d0, 0);
  endtask

  task automatic t_hold_result();
    logic [7:0] r0;
    r0 = result;
    repeat (10) @(negedge clk);
    chk(result == r0, "R12 result holds", int'(result), int'(r0));
    chk(dbl_done == 0, "R12 done one cycle", dbl_done, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #1;
    t_reset_state();
    rst = 1'b0;
    t_write(8'hA5, 0, 1'b0, "plain write");
    t_read(8'h3C, "read");
    t_touch(8'hF0, 8'h96, 1'b1, "touch with busy cmd");
    t_write(8'h11, 0, 1'b0, "R5 pu_load while busy ignored");
    t_noop();
    set_pu(3);
    t_write(8'h81, 3, 1'b1, "R7 held write");
    t_write(8'h7E, 0, 1'b0, "R8 one-shot");
    set_pu(2);
    set_pu(0);
    t_write(8'hC3, 0, 1'b0, "R9 zero cancels");
    pu_hw_en <= 1'b0;
    set_pu(2);
    t_write(8'h5A, 2, 1'b0, "R10 hw off waits");
    pu_hw_en <= 1'b1;
    set_pu(1);
    t_read(8'hE7, "R11 read keeps request");
    t_touch(8'h0F, 8'hFF, 1'b0, "R11 touch keeps request");
    t_write(8'h24, 1, 1'b1, "R11 request used by write");
    t_hold_result();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule